// File: doc/BRIEF.md
# Global-Bit-Selected One-Bit Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps two small tables of one-bit entries and a single global history bit. The global bit records the resolved direction of the most recent branch, whichever branch that was, and chooses which of the two tables supplies the prediction. Each entry simply remembers the direction its branch went the last time it resolved through that table.

A front end presents a branch address on the lookup port. In the same cycle it receives a taken or not-taken prediction and the table-select bit behind that prediction. When the branch resolves, the back end returns three things: the address, that select bit and the actual direction. One clock edge then writes the outcome into the chosen table and into the global bit, so the next lookup already sees the result.

Two counters track how many updates were made and how many of them agreed with the stored prediction.

Top module: `gsel_branch_predictor`

## Requirements
- R1: An entry predicts the direction stored by its last update. Every update overwrites the addressed entry with the actual outcome.
- R2: While `rst` is high at a rising edge, every entry of both tables, the global bit and both counters clear to 0 on that edge. The value 0 means not-taken.
- R3: Both ports form the entry index from address bits [5:2] only. Addresses that agree in those bits share an entry.
- R4: Each update loads the global bit with `up_taken`, whatever branch it was.
- R5: A lookup reads the first table when the global bit is 0 and the second when it is 1. `lk_sel` shows the global bit in use.
- R6: An update writes only the table named by `up_sel`, even when `up_sel` differs from the current global bit. The other table keeps its contents.
- R7: Lookup is combinational. A lookup in the cycle after an update observes that update in both the entry and the global bit.
- R8: `cnt_total` rises by one on every update. `cnt_correct` rises by one when the entry addressed by `up_sel` and `up_pc` already held `up_taken` before the write.
- R9: A cycle with `up_valid` low changes no entry, no global bit and no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | ADDR_W | Address of the branch being predicted |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_sel | output | 1 | Global bit used for this prediction |
| up_valid | input | 1 | An update is presented this cycle |
| up_pc | input | ADDR_W | Address of the resolved branch |
| up_sel | input | 1 | Table select captured at prediction time |
| up_taken | input | 1 | Resolved direction, 1 = taken |
| cnt_total | output | CNT_W | Number of updates since reset |
| cnt_correct | output | CNT_W | Number of updates whose stored entry matched the outcome |

## Verification
The assertions assume that `rst` is driven from time zero. They also assume that the counters never wrap, because fewer than 2^CNT_W updates occur between resets. The stimulus resets first and makes a few hundred updates, far below the 16-bit limit. It also drives `up_sel` with the value of `lk_sel` except in deliberate cases where the opposite table is named. Those cases test that a stale selector still steers the write.

// File: rtl/gbp_pkg.sv
package gbp_pkg;
  localparam int ADDR_W_DEF  = 32;
  localparam int IDX_W_DEF   = 4;
  localparam int IDX_LSB_DEF = 2;
  localparam int CNT_W_DEF   = 16;

  // Entry index: shift the address down to the first index bit.
  function automatic logic [15:0] shift_index(logic [63:0] addr, int lsb);
    return 16'(addr >> lsb);
  endfunction

  // A prediction was right when the stored bit matches the outcome.
  function automatic logic was_correct(logic stored, logic actual);
    return ~(stored ^ actual);
  endfunction
endpackage

// File: rtl/gbp_table.sv
module gbp_table #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_bit,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_bit,
  output logic             cur_bit
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] bits_q;

  always_ff @(posedge clk) begin
    if (rst)        bits_q <= '0;
    else if (wr_en) bits_q[wr_idx] <= wr_bit;
  end

  assign rd_bit  = bits_q[rd_idx];
  assign cur_bit = bits_q[wr_idx];

  p_reset_clears_r2: assert property (@(posedge clk) rst |=> bits_q == '0);
  p_entry_overwrite_r1: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> bits_q[$past(wr_idx)] == $past(wr_bit));
  p_neighbours_kept_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((bits_q ^ $past(bits_q)) & ~(DEPTH'(1) << $past(wr_idx))) == '0);
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(bits_q));
endmodule

// File: rtl/gbp_history.sv
module gbp_history (
  input  logic clk,
  input  logic rst,
  input  logic upd,
  input  logic dir,
  output logic glob
);
  always_ff @(posedge clk) begin
    if (rst)      glob <= 1'b0;
    else if (upd) glob <= dir;
  end

  p_glob_reset_r2: assert property (@(posedge clk) rst |=> !glob);
  p_glob_tracks_r4: assert property (@(posedge clk) disable iff (rst)
    upd |=> glob == $past(dir));
  p_glob_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(glob));
endmodule

// File: rtl/gbp_stats.sv
module gbp_stats #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bump,
  input  logic             hit,
  output logic [CNT_W-1:0] total,
  output logic [CNT_W-1:0] correct
);
  always_ff @(posedge clk) begin
    if (rst) begin
      total   <= '0;
      correct <= '0;
    end else if (bump) begin
      total   <= total + CNT_W'(1);
      correct <= correct + CNT_W'(hit);
    end
  end

  p_stats_reset_r2: assert property (@(posedge clk) rst |=> (total == '0 && correct == '0));
  p_total_step_r8: assert property (@(posedge clk) disable iff (rst)
    bump |=> total == $past(total) + CNT_W'(1));
  p_correct_bound_r8: assert property (@(posedge clk) disable iff (rst)
    correct <= total);
  p_stats_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !bump |=> ($stable(total) && $stable(correct)));
endmodule

// File: rtl/gsel_branch_predictor.sv
module gsel_branch_predictor #(
  parameter int ADDR_W  = gbp_pkg::ADDR_W_DEF,
  parameter int IDX_W   = gbp_pkg::IDX_W_DEF,
  parameter int IDX_LSB = gbp_pkg::IDX_LSB_DEF,
  parameter int CNT_W   = gbp_pkg::CNT_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic              lk_taken,
  output logic              lk_sel,
  input  logic              up_valid,
  input  logic [ADDR_W-1:0] up_pc,
  input  logic              up_sel,
  input  logic              up_taken,
  output logic [CNT_W-1:0]  cnt_total,
  output logic [CNT_W-1:0]  cnt_correct
);
  localparam int NTAB = 2;

  logic [IDX_W-1:0] lk_idx;
  logic [IDX_W-1:0] up_idx;
  logic [NTAB-1:0]  rd_bits;
  logic [NTAB-1:0]  cur_bits;
  logic [NTAB-1:0]  wr_hits;
  logic             glob;
  logic             upd_hit;

  assign lk_idx = IDX_W'(gbp_pkg::shift_index(64'(lk_pc), IDX_LSB));
  assign up_idx = IDX_W'(gbp_pkg::shift_index(64'(up_pc), IDX_LSB));

  for (genvar t = 0; t < NTAB; t++) begin : g_tab
    assign wr_hits[t] = up_valid && (up_sel == 1'(t));
    gbp_table #(.IDX_W(IDX_W)) u_tab (
      .clk    (clk),
      .rst    (rst),
      .rd_idx (lk_idx),
      .rd_bit (rd_bits[t]),
      .wr_en  (wr_hits[t]),
      .wr_idx (up_idx),
      .wr_bit (up_taken),
      .cur_bit(cur_bits[t])
    );
  end

  gbp_history u_hist (
    .clk (clk),
    .rst (rst),
    .upd (up_valid),
    .dir (up_taken),
    .glob(glob)
  );

  assign upd_hit = gbp_pkg::was_correct(cur_bits[up_sel], up_taken);

  gbp_stats #(.CNT_W(CNT_W)) u_stats (
    .clk    (clk),
    .rst    (rst),
    .bump   (up_valid),
    .hit    (upd_hit),
    .total  (cnt_total),
    .correct(cnt_correct)
  );

  assign lk_sel   = glob;
  assign lk_taken = rd_bits[glob];

  p_one_writer_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_hits));
  p_write_follows_valid_r9: assert property (@(posedge clk) disable iff (rst)
    up_valid |-> $countones(wr_hits) == 1);
  p_same_entry_seen_r7: assert property (@(posedge clk) disable iff (rst)
    (up_valid && up_sel == glob) |=> rd_bits[$past(up_sel)] == $past(up_taken)
      || lk_idx != $past(up_idx));
endmodule

// File: tb/sim_gsel_branch_predictor.sv
`timescale 1ns/1ps
module sim_gsel_branch_predictor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] lk_pc = '0;
  logic        lk_taken, lk_sel;
  logic        up_valid = 1'b0;
  logic [31:0] up_pc = '0;
  logic        up_sel = 1'b0;
  logic        up_taken = 1'b0;
  logic [15:0] cnt_total, cnt_correct;

  gsel_branch_predictor u0 (
    .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(lk_taken), .lk_sel(lk_sel),
    .up_valid(up_valid), .up_pc(up_pc), .up_sel(up_sel), .up_taken(up_taken),
    .cnt_total(cnt_total), .cnt_correct(cnt_correct)
  );

  always #5 clk = ~clk;

  int  tests = 0;
  int  fails = 0;
  bit  mt [2][16];
  bit  mg = 1'b0;
  int  m_total = 0;
  int  m_correct = 0;
  logic [31:0] lfsr = 32'hACE1_2468;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int t = 0; t < 2; t++) for (int i = 0; i < 16; i++) mt[t][i] = 1'b0;
    mg = 1'b0; m_total = 0; m_correct = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    model_reset();
  endtask

  // One dynamic branch: lookup, compare, then update (R1 R5 R7).
  task automatic branch(input logic [31:0] pc, input bit force_sel, input bit fsel, input bit taken, input string req);
    int  idx;
    bit  sel;
    @(negedge clk);
    lk_pc = pc;
    #2;
    idx = int'(pc[5:2]);
    check(lk_taken == mt[mg][idx], req, "prediction", int'(lk_taken), int'(mt[mg][idx]));
    check(lk_sel == mg, "R5", "lookup select", int'(lk_sel), int'(mg));
    sel = force_sel ? fsel : mg;
    up_valid = 1'b1; up_pc = pc; up_sel = sel; up_taken = taken;
    @(posedge clk); #1;
    up_valid = 1'b0;
    if (mt[sel][idx] == taken) m_correct++;
    m_total++;
    mt[sel][idx] = taken;
    mg = taken;
  endtask

  // Read every entry of the table picked by the current global bit (no update).
  task automatic sweep(input string req);
    int errs;
    int first_act;
    int first_exp;
    errs = 0; first_act = 0; first_exp = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      lk_pc = {24'h5A5A5A, 2'b11, 4'(i), 2'b01};
      #2;
      if (lk_taken != mt[mg][i]) begin
        if (errs == 0) begin first_act = int'(lk_taken) + 10 * i; first_exp = int'(mt[mg][i]) + 10 * i; end
        errs++;
      end
    end
    check(errs == 0, req, "table sweep (entry*10+bit)", first_act, first_exp);
  endtask

  task automatic chk_counts(input string req);
    #1;
    check(int'(cnt_total) == m_total, req, "cnt_total", int'(cnt_total), m_total);
    check(int'(cnt_correct) == m_correct, req, "cnt_correct", int'(cnt_correct), m_correct);
  endtask

  initial begin
    #(200000 * 10);
    fails++; tests++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int xs [9] = '{8, 9, 10, 11, 12, 20, 29, 30, 31};
    model_reset();
    repeat (2) @(negedge clk);
    rst = 1'b0;

    // R2: reset state
    @(negedge clk);
    check(lk_sel == 1'b0, "R2", "global bit after reset", int'(lk_sel), 0);
    chk_counts("R2");
    sweep("R2");

    // R1 R4 R7: two-branch loop, even test then multiple-of-ten test
    foreach (xs[k]) begin
      branch(32'h0000_0100, 1'b0, 1'b0, (xs[k] % 2) == 0, "R1");
      branch(32'h0000_0104, 1'b0, 1'b0, (xs[k] % 10) == 0, "R7");
    end
    chk_counts("R8");
    #1 check(lk_sel == mg, "R4", "global bit after loop", int'(lk_sel), int'(mg));

    // R6: write through the table not currently selected
    branch(32'h0000_0208, 1'b1, ~mg, 1'b1, "R6");
    sweep("R6");
    branch(32'h0000_0300, 1'b0, 1'b0, ~mg, "R6");
    sweep("R6");

    // R3: aliasing on bits [5:2] despite different upper and lower bits
    branch(32'h0000_0014, 1'b0, 1'b0, 1'b1, "R3");
    branch(32'h0000_0014, 1'b0, 1'b0, 1'b1, "R3");
    branch(32'hFFFF_FFD7, 1'b0, 1'b0, 1'b0, "R3");

    // Pseudo-random traffic with occasional stale selectors
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      branch(lfsr, lfsr[9:7] == 3'b101, lfsr[12], lfsr[15] ^ lfsr[3], "R1");
      if (n % 50 == 49) begin
        sweep("R5");
        chk_counts("R8");
      end
    end

    // R9: garbage on the update side with up_valid low
    @(negedge clk);
    up_valid = 1'b0; up_pc = 32'hFFFF_FFFC; up_sel = ~mg; up_taken = ~mg;
    repeat (3) @(negedge clk);
    #1 check(lk_sel == mg, "R9", "global bit held", int'(lk_sel), int'(mg));
    chk_counts("R9");
    sweep("R9");

    // R2: reset in mid-run, then inspect the second table
    do_reset();
    chk_counts("R2");
    sweep("R2");
    branch(32'h0000_003C, 1'b0, 1'b0, 1'b1, "R2");
    sweep("R2");
    chk_counts("R8");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule